// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a slave-only port on a two-wire serial control bus that holds a small bank of byte-wide configuration registers. Each bit of the bank drives a single enable for one output of a host device, so the whole bank is presented to the rest of the chip as one wide parallel vector. The bus lines are oversampled by the fast system clock through two-flop synchronizers. Start and stop conditions, SCL edges and all decisions are taken on the synchronized copies of the lines.

A master writes the bank by addressing the device for write, sending two header bytes that the block discards, and then streaming data bytes. The data bytes fill the registers in order, beginning at register 0. There is no sub-address, so changing register k means resending every register below it. A master reads the bank by addressing the device for read. It then receives a count byte followed by the registers, again from register 0 upward. The slave only ever pulls the data line low. It does this through an output enable, and its data output stays at 0.

Top module: `smbcfg_slave`

## Requirements
- R1: A falling edge of SDA while SCL is high (a start) begins address reception. A rising edge of SDA while SCL is high (a stop) ends the transfer. A start arriving in the middle of any byte abandons that transfer without changing any register, and the next byte is taken as an address.
- R2: The first byte after a start carries the 7-bit address in bits 7..1 (MSB first) and the direction in bit 0, where 1 means read. The slave pulls SDA low in the acknowledge slot only for 0xD2 (write) and 0xD3 (read). For any other address it stays released for the rest of that transfer, and no register changes.
- R3: In a write, every byte is acknowledged up to the limit. The first two bytes after the address are accepted and discarded. Data byte i (i = 0..9) then loads register i, MSB first.
- R4: Data bytes after the tenth are not acknowledged and modify no register.
- R5: In a read, the slave first sends the count byte 0x0A. It then sends register 0, register 1 and so on, MSB first, as long as the master acknowledges.
- R6: After reset, every register holds 0xFF.
- R7: A write carrying k < 10 data bytes changes registers 0..k-1 only. Registers k..9 keep their earlier contents.
- R8: The slave drives the line only by asserting `sda_oe` while `sda_out` is held at 0. `sda_oe` changes only while SCL is low.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start. A start followed at once by a stop leaves every register unchanged.
- R10: `cfg_en[8k+7:8k]` equals register k. The bank is visible on this output from the clock after the acknowledge slot of the byte that wrote it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_out | output | 1 | Data value to drive, held at 0 |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_en | output | 80 | Register bank, register k on bits 8k+7..8k |

## Verification
Two functions of this block can land in the same cycle: detecting a start condition, and the byte engine's shift and acknowledge bookkeeping. In the same synchronized sample, a start must take precedence over a half-received data byte. The bench provokes this by cutting a write off after four data bits and issuing a repeated start straight into a read. The bench judges it by the read address being acknowledged and by the returned bank being identical to the bench's model from before the interrupted write. Random writes of 1 to 12 data bytes, each followed by a full read-back, drive the other collision: the acknowledge decision and the register write both happen at the boundary of the tenth byte.

// File: rtl/smbcfg_pkg.sv
`timescale 1ns/1ps
package smbcfg_pkg;
  // Transfer phase of the byte engine
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_e;
endpackage

// File: rtl/smbcfg_line_sync.sv
`timescale 1ns/1ps
module smbcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/smbcfg_cond_detect.sv
`timescale 1ns/1ps
module smbcfg_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/smbcfg_byte_engine.sv
`timescale 1ns/1ps
module smbcfg_byte_engine
  import smbcfg_pkg::*;
#(
  parameter int         NUM_REGS = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         CNT_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [CNT_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam int         BI_W     = $clog2(NUM_REGS + 3);
  localparam logic [BI_W-1:0] BI_LIMIT = BI_W'(NUM_REGS + 2);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(NUM_REGS);

  phase_e          phase;
  logic [3:0]      bit_cnt;
  logic            in_ack;
  logic [7:0]      shreg;
  logic            is_read;
  logic            mst_nack;
  logic [BI_W-1:0] byte_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      shreg    <= '0;
      is_read  <= 1'b0;
      mst_nack <= 1'b0;
      byte_idx <= '0;
      rd_idx   <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      sda_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase    <= PH_ADDR;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        byte_idx <= '0;
        rd_idx   <= '0;
        mst_nack <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (in_ack) begin
            if (phase == PH_READ) mst_nack <= sda_s;
          end else if (bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 4'd1;
            if (phase != PH_READ) shreg <= {shreg[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            // end of the acknowledge slot
            in_ack  <= 1'b0;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
            if (phase == PH_ADDR) begin
              if (is_read) begin
                phase  <= PH_READ;
                shreg  <= CNT_BYTE;
                sda_oe <= ~CNT_BYTE[7];
              end else begin
                phase <= PH_WRITE;
              end
            end else if (phase == PH_READ) begin
              if (mst_nack) begin
                phase <= PH_IDLE;
              end else begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                if (rd_idx < RD_LAST) rd_idx <= rd_idx + CNT_W'(1);
              end
            end
          end else if (bit_cnt == 4'd8) begin
            // start of the acknowledge slot
            in_ack <= 1'b1;
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_WRITE: begin
                if (byte_idx < BI_LIMIT) begin
                  sda_oe   <= 1'b1;
                  byte_idx <= byte_idx + BI_W'(1);
                  if (byte_idx >= BI_W'(2)) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= CNT_W'(byte_idx - BI_W'(2));
                    wr_data <= shreg;
                  end
                end else begin
                  phase <= PH_IDLE;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (phase == PH_READ) begin
            shreg  <= {shreg[6:0], 1'b1};
            sda_oe <= ~shreg[6];
          end
        end
      end
    end
  end

  // R8
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe)) |-> !scl_s);

  // R4
  write_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < CNT_W'(NUM_REGS)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (phase != PH_IDLE));

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (phase == PH_ADDR && bit_cnt == 4'd0 && !sda_oe));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_READ && in_ack && mst_nack && scl_fall && !start_det && !stop_det)
      |=> (phase == PH_IDLE && !sda_oe));
endmodule

// File: rtl/smbcfg_reg_bank.sv
`timescale 1ns/1ps
module smbcfg_reg_bank #(
  parameter int NUM_REGS = 10,
  parameter int CNT_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [CNT_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [CNT_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);
  logic [7:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 8'hFF;
    end else if (wr_en && (wr_idx < CNT_W'(NUM_REGS))) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign rd_data = (rd_idx < CNT_W'(NUM_REGS)) ? regs[rd_idx] : 8'hFF;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_flat
    assign cfg_flat[8*k +: 8] = regs[k];
  end

  // R6
  reset_ones_chk: assert property (@(posedge clk) rst |=> (&cfg_flat));
endmodule

// File: rtl/smbcfg_slave.sv
`timescale 1ns/1ps
module smbcfg_slave #(
  parameter int         NUM_REGS    = 10,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_out,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_en
);
  localparam int CNT_W = $clog2(NUM_REGS + 1);

  logic [1:0] line_raw, line_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, wr_data;
  logic [CNT_W-1:0] rd_idx, wr_idx;
  logic wr_en;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    smbcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(line_raw[g]), .dout(line_s[g])
    );
  end

  smbcfg_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbcfg_byte_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  smbcfg_reg_bank #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .cfg_flat(cfg_en)
  );

  assign sda_out = 1'b0;

  // R8
  drive_low_only_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (sda_out == 1'b0));
endmodule

// File: tb/smbcfg_slave_test.sv
`timescale 1ns/1ps
module smbcfg_slave_test;
  localparam int NR = 10;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_out, sda_oe;
  logic [NR*8-1:0] cfg_en;
  wire  sda_line = sda_oe ? sda_out : sda_m;

  int tests = 0;
  int fails = 0;
  int oe_viol = 0;
  int out_viol = 0;
  logic [7:0] exp_regs [NR];
  logic [7:0] wbuf [12];

  always #2.5 clk = ~clk;

  smbcfg_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_out(sda_out), .sda_oe(sda_oe), .cfg_en(cfg_en)
  );

  // R8 monitor: enable may only move while SCL is low
  logic prev_oe = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      if (sda_oe !== prev_oe && scl_m) oe_viol++;
      if (sda_out !== 1'b0) out_viol++;
    end
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] exp_flat();
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[8*k +: 8] = exp_regs[k];
    return v;
  endfunction

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    if (!scl_m) begin sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); end
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    wq(); sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!mack);
  endtask

  // write n data bytes from wbuf; checks acks against the model
  task automatic do_write(input int n, input string tag);
    logic ack;
    int bad = 0;
    bus_start();
    send_byte(8'hD2, ack); if (!ack) bad++;
    send_byte(8'($urandom), ack); if (!ack) bad++;
    send_byte(8'(n), ack); if (!ack) bad++;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      if (ack !== (i < NR)) bad++;
      if (i < NR) exp_regs[i] = wbuf[i];
    end
    bus_stop();
    chk({tag, " ack pattern"}, bad, 0);
  endtask

  // read count and the whole bank, compare to model
  task automatic do_read(input string tag);
    logic ack;
    logic [7:0] v;
    int bad = 0;
    bus_start();
    send_byte(8'hD3, ack);
    chk({tag, " R2 read address ack"}, ack, 1'b1);
    recv_byte(1'b1, v);
    chk({tag, " R5 count byte"}, v, 8'h0A);
    for (int i = 0; i < NR; i++) begin
      recv_byte(i != NR - 1, v);
      if (v !== exp_regs[i]) bad++;
    end
    wq();
    chk({tag, " R9 released after master nack"}, sda_oe, 1'b0);
    bus_stop();
    chk({tag, " R5 register bytes"}, bad, 0);
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd2718));
    for (int k = 0; k < NR; k++) exp_regs[k] = 8'hFF;
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    wq();
    // R6 / R10: reset contents
    chk("R6 reset all ones", cfg_en, {NR{8'hFF}});
    chk("R8 idle release", sda_oe, 1'b0);

    // R3 / R10: full directed write
    for (int i = 0; i < NR; i++) wbuf[i] = 8'(8'h11 * (i + 1)) ^ 8'h5A;
    do_write(NR, "R3 full write");
    chk("R10 bank on output", cfg_en, exp_flat());
    do_read("R5 full read");

    // R7: partial write of 3
    for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hA0 + i);
    do_write(3, "R7 partial write");
    chk("R7 upper registers kept", cfg_en, exp_flat());

    // R4: 12 data bytes, last two refused
    for (int i = 0; i < 12; i++) wbuf[i] = 8'(8'h30 + 7 * i);
    do_write(12, "R4 overlong write");
    chk("R4 bank after overlong write", cfg_en, exp_flat());

    // R2: wrong address, nothing acknowledged, bank kept
    bus_start();
    send_byte(8'hD4, ack);
    chk("R2 foreign address silent", ack, 1'b0);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    chk("R2 later bytes silent", ack, 1'b0);
    bus_stop();
    chk("R2 bank unchanged", cfg_en, exp_flat());

    // R9: bare start then stop
    bus_start();
    bus_stop();
    chk("R9 start-stop no effect", cfg_en, exp_flat());

    // R1: start in the middle of a data byte aborts the write
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h00, ack);
    send_byte(8'h01, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_read("R1 restart mid byte");
    chk("R1 bank unchanged after abort", cfg_en, exp_flat());

    // random mix
    for (int it = 0; it < 7; it++) begin
      int n;
      n = int'($urandom_range(12, 1));
      for (int i = 0; i < 12; i++) wbuf[i] = 8'($urandom);
      do_write(n, "R3 random write");
      chk("R7 random bank", cfg_en, exp_flat());
      do_read("R5 random read");
    end

    chk("R8 enable moved only with SCL low", oe_viol, 0);
    chk("R8 data output held low", out_viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule